// File: doc/BRIEF.md
# Windowed-pointer I2C register slave

This block is a two-wire serial slave for standard-mode buses (0 to 100 kHz). It lets a host reach a 50-location space (0x00 to 0x31) made of a control register, an interrupt-enable register and a read-only data store. The bus is sampled with the system clock. START and STOP are found from the sampled lines. The block answers its device address and acknowledges every byte it receives. It drives SDA only by pulling it low. A level on `addr_sel` picks one of two device addresses, so two of these slaves can share one bus.

A write transfer first loads a word pointer. Any further bytes in that transfer are written at the pointer. A read transfer returns bytes from the pointer, most significant bit first. The read source is an external port, so the surrounding logic supplies the status byte and the stored data. After each byte the pointer moves on only inside two windows, 0x02 to 0x0F and 0x11 to 0x31. In each window it stops at the top address. Outside the windows every location is direct access and the pointer stays put. A one-cycle `status_rd` pulse tells the owner of the status byte that the host has fetched it, so the owner can clear its flags.

Top module: `segptr_i2c_slave`

## Requirements
- R1: The 7-bit device address is 0x11 when `addr_sel` is 0 and 0x10 when it is 1, followed by the R/W bit (1 = read). On a match the slave pulls SDA low during the ninth clock. Without a match it leaves SDA released and ignores the bus until the next START.
- R2: In a write transfer the first byte after the device address loads the pointer. That byte and every later byte are acknowledged by the slave.
- R3: A write byte at pointer 0x00 sets `ctrl_reg`, and one at 0x01 sets `irq_reg`. A write byte at any other pointer changes neither register.
- R4: When the pointer is 0x00, 0x01, 0x10 or any address outside both windows, it does not change after a byte is transferred.
- R5: Inside 0x02 to 0x0F the pointer increases by one after each transferred byte and holds at 0x0F.
- R6: Inside 0x11 to 0x31 the pointer increases by one after each transferred byte and holds at 0x31.
- R7: `rd_addr` always shows the pointer. A read byte is the `rd_data` value at the pointer, sent MSB first. In a read, the pointer advances only after the master acknowledges the byte. After a master NACK, SDA stays released and the pointer stays unchanged until STOP or START.
- R8: `status_rd` pulses high for one cycle once all eight bits of a byte read from 0x00 have been sent. A read from any other address gives no pulse.
- R9: After reset, SDA is released, the pointer is 0x00, both registers are 0x00 and `status_rd` is low.
- R10: A repeated START after a pointer write begins a read at that pointer.
- R11: A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| addr_sel | input | 1 | Selects device address 0x11 (0) or 0x10 (1) |
| rd_addr | output | 8 | Current word pointer, used as the read address |
| rd_data | input | 8 | Byte stored at `rd_addr` (status byte at 0x00) |
| ctrl_reg | output | 8 | Control register, written at 0x00 |
| irq_reg | output | 8 | Interrupt-enable register, written at 0x01 |
| status_rd | output | 1 | One-cycle pulse after the status byte is sent |

## Verification
The embedded properties watch, on every cycle, that the pointer only ever steps by one or is reloaded, and that it holds at each window's top address and at the direct locations. They also check that the registers change only when the pointer is at their own address, that SDA is released while idle or parked and moves only while SCL is low, and that the status pulse lasts one cycle and only at 0x00. Only the directed scenarios can show end-to-end facts that need a whole bus transfer. These are: which device address is answered for each `addr_sel` level, the exact byte order returned by bursts that cross a stop address, the pointer frozen by a master NACK, and pointer reuse across a repeated START.

// File: rtl/segptr_pkg.sv
package segptr_pkg;
   localparam int PTR_W = 8;
   localparam int BYTE_W = 8;
   localparam int CNT_W = 4;
   localparam logic [PTR_W-1:0] CTRL_ADR = 8'h00;
   localparam logic [PTR_W-1:0] IRQ_ADR  = 8'h01;
   localparam logic [PTR_W-1:0] GAP_ADR  = 8'h10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_DEVACK,
      ST_WRBYTE,
      ST_WRACK,
      ST_RDBYTE,
      ST_RDACK,
      ST_PARK
   } xfer_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sampler: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_prev <= scl_pipe[STAGES-1];
         sda_prev <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl   = scl_pipe[STAGES-1];
   assign sda_lvl   = sda_pipe[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ptr_window_seq.sv
module ptr_window_seq
   import segptr_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN*PTR_W-1:0] WIN_LO = {8'h11, 8'h02},
   parameter logic [NUM_WIN*PTR_W-1:0] WIN_HI = {8'h31, 8'h0F}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr_q
);
   logic [NUM_WIN-1:0] in_win;
   logic               may_step;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam logic [PTR_W-1:0] LO = WIN_LO[i*PTR_W +: PTR_W];
      localparam logic [PTR_W-1:0] HI = WIN_HI[i*PTR_W +: PTR_W];
      if (LO >= HI) begin : g_bad_win
         $error("ptr_window_seq: window low bound must be below its stop address");
      end
      // a window steps from its low bound up to, but not past, its stop address
      assign in_win[i] = (ptr_q >= LO) && (ptr_q < HI);

      AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(adv) && !$past(load) && $past(ptr_q) == HI) |-> (ptr_q == HI)); // R5 R6
   end

   assign may_step = |in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= CTRL_ADR;
      end else if (load) begin
         ptr_q <= load_val;
      end else if (adv && may_step) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && ptr_q != $past(ptr_q)) |-> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R5
   AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && (ptr_q == CTRL_ADR || ptr_q == IRQ_ADR || ptr_q == GAP_ADR))
      |=> $stable(ptr_q)); // R4
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
   import segptr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [6:0]        my_addr,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              ptr_load,
   output logic              ptr_adv,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] byte_q,
   output logic              status_rd
);
   localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] FULL_RX = CNT_W'(BYTE_W);

   xfer_state_t       st;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  bitcnt;
   logic              rnw, first_wr, mack, from_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         shreg     <= '0;
         bitcnt    <= '0;
         rnw       <= 1'b0;
         first_wr  <= 1'b0;
         mack      <= 1'b0;
         from_ctl  <= 1'b0;
         sda_oe    <= 1'b0;
         ptr_load  <= 1'b0;
         ptr_adv   <= 1'b0;
         wr_stb    <= 1'b0;
         byte_q    <= '0;
         status_rd <= 1'b0;
      end else begin
         ptr_load  <= 1'b0;
         ptr_adv   <= 1'b0;
         wr_stb    <= 1'b0;
         status_rd <= 1'b0;
         if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            st     <= ST_DEVADR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_DEVADR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + CNT_W'(1);
                  end else if (scl_fall && bitcnt == FULL_RX) begin
                     if (shreg[BYTE_W-1:1] == my_addr) begin
                        st     <= ST_DEVACK;
                        sda_oe <= 1'b1;
                        rnw    <= shreg[0];
                     end else begin
                        st <= ST_PARK;
                     end
                  end
               end
               ST_DEVACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rnw) begin
                        st       <= ST_RDBYTE;
                        shreg    <= rd_data;
                        sda_oe   <= ~rd_data[BYTE_W-1];
                        from_ctl <= (ptr == CTRL_ADR);
                     end else begin
                        st       <= ST_WRBYTE;
                        sda_oe   <= 1'b0;
                        first_wr <= 1'b1;
                     end
                  end
               end
               ST_WRBYTE: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + CNT_W'(1);
                  end else if (scl_fall && bitcnt == FULL_RX) begin
                     st       <= ST_WRACK;
                     sda_oe   <= 1'b1;
                     byte_q   <= shreg;
                     first_wr <= 1'b0;
                     if (first_wr) begin
                        ptr_load <= 1'b1;
                     end else begin
                        wr_stb  <= 1'b1;
                        ptr_adv <= 1'b1;
                     end
                  end
               end
               ST_WRACK: begin
                  if (scl_fall) begin
                     st     <= ST_WRBYTE;
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                  end
               end
               ST_RDBYTE: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_TX) begin
                        st        <= ST_RDACK;
                        sda_oe    <= 1'b0;
                        bitcnt    <= '0;
                        status_rd <= from_ctl;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                        bitcnt <= bitcnt + CNT_W'(1);
                     end
                  end
               end
               ST_RDACK: begin
                  if (scl_rise) begin
                     mack    <= ~sda_lvl;
                     ptr_adv <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st       <= ST_RDBYTE;
                        shreg    <= rd_data;
                        sda_oe   <= ~rd_data[BYTE_W-1];
                        from_ctl <= (ptr == CTRL_ADR);
                     end else begin
                        st <= ST_PARK;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_PARK) |-> !sda_oe); // R11
   AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl); // R7
   AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd |=> !status_rd); // R8
endmodule

// File: rtl/segptr_i2c_slave.sv
module segptr_i2c_slave
   import segptr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR_LO = 7'h11,
   parameter logic [6:0] DEV_ADDR_HI = 7'h10,
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN*PTR_W-1:0] WIN_LO = {8'h11, 8'h02},
   parameter logic [NUM_WIN*PTR_W-1:0] WIN_HI = {8'h31, 8'h0F}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              addr_sel,
   output logic [PTR_W-1:0]  rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] ctrl_reg,
   output logic [BYTE_W-1:0] irq_reg,
   output logic              status_rd
);
   if (DEV_ADDR_LO == DEV_ADDR_HI) begin : g_bad_addr
      $error("segptr_i2c_slave: the two device addresses must differ");
   end

   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic              ptr_load, ptr_adv, wr_stb;
   logic [BYTE_W-1:0] byte_q;
   logic [6:0]        my_addr;

   assign my_addr = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;

   i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2c_xfer_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .my_addr(my_addr), .ptr(rd_addr),
      .rd_data(rd_data), .sda_oe(sda_oe), .ptr_load(ptr_load),
      .ptr_adv(ptr_adv), .wr_stb(wr_stb), .byte_q(byte_q),
      .status_rd(status_rd)
   );

   ptr_window_seq #(.NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(byte_q),
      .adv(ptr_adv), .ptr_q(rd_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_reg <= '0;
         irq_reg  <= '0;
      end else if (wr_stb) begin
         if (rd_addr == CTRL_ADR) ctrl_reg <= byte_q;
         if (rd_addr == IRQ_ADR)  irq_reg  <= byte_q;
      end
   end

   AST_CTRL_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_reg) |-> ($past(rd_addr) == CTRL_ADR)); // R3
   AST_IRQ_ONLY_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_reg) |-> ($past(rd_addr) == IRQ_ADR)); // R3
   AST_STATUS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd |-> (rd_addr == CTRL_ADR)); // R8
endmodule

// File: tb/test_segptr_i2c_slave.sv
module test_segptr_i2c_slave;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda_low = 1'b0;
   logic       addr_sel = 1'b0;
   logic       sda_oe;
   logic       sda_bus;
   logic [7:0] rd_addr, rd_data, ctrl_reg, irq_reg;
   logic       status_rd;
   int         n_chk = 0;
   int         n_fail = 0;
   int         n_stat = 0;

   always #10 clk = ~clk;

   assign sda_bus = ~(sda_oe | m_sda_low);

   function automatic logic [7:0] mem_val(input logic [7:0] a);
      return {a[3:0], a[7:4]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] exp_next(input logic [7:0] a);
      if ((a >= 8'h02 && a < 8'h0F) || (a >= 8'h11 && a < 8'h31)) return a + 8'd1;
      return a;
   endfunction

   assign rd_data = mem_val(rd_addr);

   segptr_i2c_slave i_segptr_i2c_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .rd_addr(rd_addr),
      .rd_data(rd_data), .ctrl_reg(ctrl_reg), .irq_reg(irq_reg),
      .status_rd(status_rd)
   );

   always @(posedge clk) if (rst_n && status_rd) n_stat++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic qwait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0; qwait(Q);
      m_scl = 1'b1;     qwait(Q);
      m_sda_low = 1'b1; qwait(Q);
      m_scl = 1'b0;     qwait(Q);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; qwait(Q);
      m_scl = 1'b1;     qwait(Q);
      m_sda_low = 1'b0; qwait(2 * Q);
   endtask

   task automatic put_bit(input logic b);
      m_sda_low = ~b; qwait(Q);
      m_scl = 1'b1;   qwait(2 * Q);
      m_scl = 1'b0;   qwait(Q);
   endtask

   task automatic get_bit(output logic b);
      m_sda_low = 1'b0; qwait(Q);
      m_scl = 1'b1;     qwait(Q);
      b = sda_bus;      qwait(Q);
      m_scl = 1'b0;     qwait(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic bb;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(bb);
      ack = ~bb;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic ack);
      logic bb;
      for (int i = 7; i >= 0; i--) begin
         get_bit(bb);
         v[i] = bb;
      end
      put_bit(~ack);
      m_sda_low = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 sda released", sda_oe, 0);
      chk("R9 pointer", rd_addr, 8'h00);
      chk("R9 ctrl", ctrl_reg, 8'h00);
      chk("R9 irq", irq_reg, 8'h00);
      chk("R9 status pulse", status_rd, 0);
   endtask

   task automatic t_wrong_addr();
      logic ack;
      addr_sel = 1'b0;
      bus_start();
      send_byte({7'h10, 1'b0}, ack);
      chk("R1 foreign address not acked", ack, 0);
      send_byte(8'h00, ack);
      chk("R1 parked slave gives no ack", ack, 0);
      send_byte(8'h77, ack);
      bus_stop();
      chk("R1 ctrl untouched by foreign transfer", ctrl_reg, 8'h00);
      chk("R1 pointer untouched by foreign transfer", rd_addr, 8'h00);
   endtask

   task automatic t_ctrl_write();
      logic ack;
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      chk("R1 own address acked (sel=0)", ack, 1);
      send_byte(8'h00, ack);
      chk("R2 pointer byte acked", ack, 1);
      send_byte(8'h13, ack);
      chk("R2 data byte acked", ack, 1);
      chk("R3 ctrl written", ctrl_reg, 8'h13);
      send_byte(8'h07, ack);
      chk("R4 second byte lands at 0x00 again", ctrl_reg, 8'h07);
      chk("R4 pointer held at 0x00", rd_addr, 8'h00);
      bus_stop();
      qwait(Q);
      chk("R11 released after STOP", sda_oe, 0);
   endtask

   task automatic t_irq_write();
      logic ack;
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      send_byte(8'h01, ack);
      send_byte(8'h60, ack);
      bus_stop();
      chk("R3 irq written", irq_reg, 8'h60);
      chk("R3 ctrl unchanged by irq write", ctrl_reg, 8'h07);
      chk("R4 pointer held at 0x01", rd_addr, 8'h01);
   endtask

   task automatic t_gap_write();
      logic ack;
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      send_byte(8'h10, ack);
      send_byte(8'hAA, ack);
      chk("R2 write at 0x10 acked", ack, 1);
      send_byte(8'hBB, ack);
      bus_stop();
      chk("R3 ctrl unchanged by 0x10 write", ctrl_reg, 8'h07);
      chk("R3 irq unchanged by 0x10 write", irq_reg, 8'h60);
      chk("R4 pointer held at 0x10", rd_addr, 8'h10);
   endtask

   task automatic t_window_write();
      logic ack;
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      send_byte(8'h04, ack);
      send_byte(8'h99, ack);
      bus_stop();
      chk("R5 write in low window advances pointer", rd_addr, 8'h05);
      chk("R3 ctrl unchanged by window write", ctrl_reg, 8'h07);
   endtask

   task automatic rd_burst(input string tag, input logic [7:0] dev, input logic [7:0] p,
                           input int n);
      logic       ack;
      logic [7:0] v;
      logic [7:0] e;
      e = p;
      bus_start();
      send_byte({dev[6:0], 1'b0}, ack);
      send_byte(p, ack);
      bus_start();
      send_byte({dev[6:0], 1'b1}, ack);
      chk({tag, " R10 read address acked after repeated START"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(v, k != n - 1);
         chk({tag, " R7 read byte value"}, v, mem_val(e));
         if (k != n - 1) e = exp_next(e);
      end
      qwait(2 * Q);
      chk({tag, " R7 SDA released after NACK"}, sda_oe, 0);
      chk({tag, " R7 pointer unchanged by NACK"}, rd_addr, e);
      bus_stop();
   endtask

   task automatic t_reads();
      int s0;
      rd_burst("R5 low window stop", 8'h11, 8'h0D, 4);
      rd_burst("R6 high window stop", 8'h11, 8'h2F, 4);
      rd_burst("R6 high window start", 8'h11, 8'h11, 3);
      s0 = n_stat;
      rd_burst("R8 no pulse off 0x00", 8'h11, 8'h05, 2);
      chk("R8 no status pulse for 0x05", n_stat - s0, 0);
      rd_burst("R7 single byte", 8'h11, 8'h03, 1);
   endtask

   task automatic t_status_alt_addr();
      logic ack;
      int   s0;
      addr_sel = 1'b1;
      bus_start();
      send_byte({7'h11, 1'b0}, ack);
      chk("R1 0x11 ignored when sel=1", ack, 0);
      bus_stop();
      s0 = n_stat;
      rd_burst("R1 R8 status via 0x10", 8'h10, 8'h00, 2);
      chk("R8 one pulse per status byte", n_stat - s0, 2);
      rd_burst("R4 direct read 0x10", 8'h10, 8'h10, 3);
      addr_sel = 1'b0;
   endtask

   task automatic t_current_read();
      logic       ack;
      logic [7:0] v;
      bus_start();
      send_byte({7'h11, 1'b1}, ack);
      chk("R7 current-address read acked", ack, 1);
      recv_byte(v, 1'b0);
      chk("R7 read starts at held pointer 0x10", v, mem_val(8'h10));
      bus_stop();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      qwait(5);
      t_reset();
      rst_n = 1'b1;
      qwait(5);
      t_reset();
      t_wrong_addr();
      t_ctrl_write();
      t_irq_write();
      t_gap_write();
      t_window_write();
      t_reads();
      t_status_alt_addr();
      t_current_read();
      summary();
      $finish;
   end
endmodule